// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block works out which page-organised serial flash sits on a shared SPI link and reports its geometry: the number of pages, the page size in bytes, and the shift that places the page number above the byte offset in a flash address. A run starts by itself when reset is released. After that, a new run starts on each request. The block talks to an external SPI bit engine through a byte port. For each byte it presents the byte to send and a flag that closes the chip-select frame after that byte, and the engine returns the received byte with a done pulse.

A run always begins with an identification frame: opcode 0x9F followed by three filler bytes, which return the manufacturer code and a two-byte device code. When the manufacturer matches, the 24-bit ID is looked up in a table. Some matched parts can run in either a binary (power-of-two) or a non-binary page mode. For these the block also reads the status byte with opcode 0xD7, and status bit 0 chooses the mode. When the manufacturer does not match, the block falls back to reading the status byte and decoding the density code in bits 5:2. The result stays on the outputs, with a valid level, until the next request.

Top module: `flashgeo`

## Requirements
- R1: After reset release a run starts with no request. Every run opens with a four-byte frame: 0x9F, then 0x00, 0x00, 0x00, with the frame-close flag only on the fourth byte. `geo_valid` is 0 from reset until the first result.
- R2: ID 0x1F2700 reports 8192 pages of 528 bytes with shift 10 and revision flag 0, and no status frame is sent.
- R3: IDs with a binary option (0x1F2200, 0x1F2300, 0x1F2400, 0x1F2500, 0x1F2600, 0x1F2701, 0x1F2800) cause a two-byte status frame: 0xD7, then 0x00 with the close flag set. Status bit 0 set selects the binary size, and clear selects the non-binary size. The size families are 256 (shift 8) or 264 (shift 9) for 0x1F22..0x1F25; 512 (9) or 528 (10) for 0x1F26 and 0x1F2701; 1024 (10) or 1056 (11) for 0x1F28.
- R4: Page counts by ID: 0x1F22 gives 512, 0x1F23 gives 1024, 0x1F24 gives 2048, 0x1F25 and 0x1F26 give 4096, and 0x1F27xx and 0x1F28 give 8192.
- R5: A manufacturer byte of 0x1F combined with any other 24-bit ID reports unsupported, and no status frame is sent.
- R6: A manufacturer byte other than 0x1F causes the status frame of R3. A status byte of 0x00 or 0xFF then reports unsupported.
- R7: On that fallback path, status bits 5:2 decode as follows: 3 gives 512x264, 5 gives 1024x264, 7 gives 2048x264, 9 gives 4096x264, 0xB gives 4096x528, 0xD gives 8192x528, and 0xE or 0xF gives 8192x1056. The shifts are 9, 10 and 11 for sizes 264, 528 and 1056. Every other code is unsupported. The revision flag is 0.
- R8: `geo_rev` is 1 exactly when the matched ID has a binary page option.
- R9: While `geo_valid` is 1, the byte port is idle and every result output is constant. A request made while `geo_valid` is 1 clears it on the next cycle and starts a new run.
- R10: `xfer_req`, `xfer_tx` and `xfer_last` stay constant from the cycle a byte is offered until the cycle `xfer_done` acknowledges it.
- R11: An unsupported result has `geo_ok` 0 with pages, size, shift and `geo_rev` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_req | input | 1 | Start a new identification; sampled while a result is held |
| xfer_req | output | 1 | A byte is offered to the SPI engine |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_last | output | 1 | Release chip select after this byte |
| xfer_done | input | 1 | Engine finished the offered byte |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_done |
| geo_valid | output | 1 | Result outputs are valid and held |
| geo_ok | output | 1 | Device recognised |
| geo_rev | output | 1 | Device has a binary page option |
| geo_pages | output | PAGES_W | Number of pages |
| geo_size | output | SIZE_W | Page size in bytes |
| geo_shift | output | SHIFT_W | Page address shift |

## Verification
On every cycle, the assertions check the byte-port handshake, that the result is held while valid, that a request restarts a run, that unsupported results are zeroed, and that each reported size is consistent with its shift. The assertions cannot tell which geometry belongs to which ID or status code, or whether the status frame was sent on exactly the right paths. Only the bench shows these. It sweeps every status value on the fallback path and a grid of device codes and mode bits around the table on the ID path.

// File: rtl/flashgeo_pkg.sv
package flashgeo_pkg;

   localparam logic [7:0] OP_GET_ID   = 8'h9F;
   localparam logic [7:0] OP_GET_STAT = 8'hD7;
   localparam logic [7:0] FILLER      = 8'h00;

   typedef enum logic [3:0] {
      ST_ID_OP, ST_ID_B0, ST_ID_B1, ST_ID_B2, ST_SORT,
      ST_SR_OP, ST_SR_B0, ST_COMMIT, ST_HOLD
   } step_e;

   // one family of parts: pages = 512 << pg_exp, size class picks 2^(8+cls)
   typedef struct packed {
      logic       hit;
      logic       pow2cap;
      logic [2:0] pg_exp;
      logic [1:0] sz_cls;
   } fam_t;

endpackage

// File: rtl/flashgeo_idmap.sv
module flashgeo_idmap
   import flashgeo_pkg::*;
#(
   parameter logic [7:0] MFR_CODE = 8'h1F
) (
   input  logic [23:0] id_word,
   output fam_t        fam
);

   function automatic fam_t mk(input logic cap, input int pg, input int cls);
      fam_t f;
      f.hit     = 1'b1;
      f.pow2cap = cap;
      f.pg_exp  = 3'(pg);
      f.sz_cls  = 2'(cls);
      return f;
   endfunction

   always_comb begin
      fam = '0;
      if (id_word[23:16] == MFR_CODE) begin
         case (id_word[15:0])
            16'h2200: fam = mk(1'b1, 0, 0);
            16'h2300: fam = mk(1'b1, 1, 0);
            16'h2400: fam = mk(1'b1, 2, 0);
            16'h2500: fam = mk(1'b1, 3, 0);
            16'h2600: fam = mk(1'b1, 3, 1);
            16'h2700: fam = mk(1'b0, 4, 1);
            16'h2701: fam = mk(1'b1, 4, 1);
            16'h2800: fam = mk(1'b1, 4, 2);
            default:  fam = '0;
         endcase
      end
   end

endmodule

// File: rtl/flashgeo_stdec.sv
module flashgeo_stdec (
   input  logic [7:0] stat,
   output logic       hit,
   output logic [2:0] pg_exp,
   output logic [1:0] sz_cls
);

   logic absent;
   assign absent = (stat == 8'h00) || (stat == 8'hFF);

   always_comb begin
      hit    = 1'b1;
      pg_exp = 3'd0;
      sz_cls = 2'd0;
      case (stat[5:2])
         4'h3:       begin pg_exp = 3'd0; sz_cls = 2'd0; end
         4'h5:       begin pg_exp = 3'd1; sz_cls = 2'd0; end
         4'h7:       begin pg_exp = 3'd2; sz_cls = 2'd0; end
         4'h9:       begin pg_exp = 3'd3; sz_cls = 2'd0; end
         4'hB:       begin pg_exp = 3'd3; sz_cls = 2'd1; end
         4'hD:       begin pg_exp = 3'd4; sz_cls = 2'd1; end
         4'hE, 4'hF: begin pg_exp = 3'd4; sz_cls = 2'd2; end
         default:    hit = 1'b0;
      endcase
      if (absent) hit = 1'b0;
   end

endmodule

// File: rtl/flashgeo_shape.sv
module flashgeo_shape #(
   parameter int PAGES_W = 14,
   parameter int SIZE_W  = 11,
   parameter int SHIFT_W = 4
) (
   input  logic               found,
   input  logic [2:0]         pg_exp,
   input  logic [1:0]         sz_cls,
   input  logic               binary,
   output logic [PAGES_W-1:0] pages,
   output logic [SIZE_W-1:0]  size,
   output logic [SHIFT_W-1:0] shift
);

   localparam int BASE_EXP = 8;
   localparam int SPARE_GAP = 5;
   localparam logic [PAGES_W-1:0] PG_MIN = PAGES_W'(512);
   localparam logic [SIZE_W-1:0]  ONE_SZ = SIZE_W'(1);

   logic [3:0] exp_b;
   assign exp_b = 4'(BASE_EXP) + {2'b00, sz_cls};

   always_comb begin
      pages = '0;
      size  = '0;
      shift = '0;
      if (found) begin
         pages = PG_MIN << pg_exp;
         if (binary) begin
            size  = ONE_SZ << exp_b;
            shift = SHIFT_W'(exp_b);
         end else begin
            size  = (ONE_SZ << exp_b) + (ONE_SZ << (exp_b - 4'(SPARE_GAP)));
            shift = SHIFT_W'(exp_b + 4'd1);
         end
      end
   end

endmodule

// File: rtl/flashgeo_seq.sv
module flashgeo_seq
   import flashgeo_pkg::*;
#(
   parameter bit         LEGACY_EN = 1'b1,
   parameter logic [7:0] MFR_CODE  = 8'h1F
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        id_req,
   input  logic        xfer_done,
   input  logic [7:0]  xfer_rx,
   input  logic        id_hit,
   input  logic        id_cap,
   output logic        xfer_req,
   output logic [7:0]  xfer_tx,
   output logic        xfer_last,
   output logic [23:0] id_word,
   output logic [7:0]  stat_byte,
   output logic        legacy,
   output logic        commit,
   output logic        idle
);

   step_e state, state_nx;
   logic  mfr_match;

   assign mfr_match = (id_word[23:16] == MFR_CODE);

   always_comb begin
      xfer_req  = 1'b0;
      xfer_tx   = FILLER;
      xfer_last = 1'b0;
      case (state)
         ST_ID_OP: begin xfer_req = 1'b1; xfer_tx = OP_GET_ID; end
         ST_ID_B0, ST_ID_B1: xfer_req = 1'b1;
         ST_ID_B2: begin xfer_req = 1'b1; xfer_last = 1'b1; end
         ST_SR_OP: begin xfer_req = 1'b1; xfer_tx = OP_GET_STAT; end
         ST_SR_B0: begin xfer_req = 1'b1; xfer_last = 1'b1; end
         default: ;
      endcase
   end

   always_comb begin
      state_nx = state;
      case (state)
         ST_ID_OP: if (xfer_done) state_nx = ST_ID_B0;
         ST_ID_B0: if (xfer_done) state_nx = ST_ID_B1;
         ST_ID_B1: if (xfer_done) state_nx = ST_ID_B2;
         ST_ID_B2: if (xfer_done) state_nx = ST_SORT;
         ST_SORT: begin
            if (!mfr_match)
               state_nx = LEGACY_EN ? ST_SR_OP : ST_COMMIT;
            else if (id_hit && id_cap)
               state_nx = ST_SR_OP;
            else
               state_nx = ST_COMMIT;
         end
         ST_SR_OP: if (xfer_done) state_nx = ST_SR_B0;
         ST_SR_B0: if (xfer_done) state_nx = ST_COMMIT;
         ST_COMMIT: state_nx = ST_HOLD;
         ST_HOLD:  if (id_req) state_nx = ST_ID_OP;
         default:  state_nx = ST_ID_OP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_ID_OP;
         id_word   <= '0;
         stat_byte <= '0;
         legacy    <= 1'b0;
      end else begin
         state <= state_nx;
         case (state)
            ST_ID_OP: stat_byte <= '0;
            ST_ID_B0: if (xfer_done) id_word[23:16] <= xfer_rx;
            ST_ID_B1: if (xfer_done) id_word[15:8]  <= xfer_rx;
            ST_ID_B2: if (xfer_done) id_word[7:0]   <= xfer_rx;
            ST_SORT:  legacy <= !mfr_match && LEGACY_EN;
            ST_SR_B0: if (xfer_done) stat_byte <= xfer_rx;
            default: ;
         endcase
      end
   end

   assign commit = (state == ST_COMMIT);
   assign idle   = (state == ST_HOLD);

endmodule

// File: rtl/flashgeo.sv
module flashgeo
   import flashgeo_pkg::*;
#(
   parameter int         PAGES_W   = 14,
   parameter int         SIZE_W    = 11,
   parameter int         SHIFT_W   = 4,
   parameter bit         LEGACY_EN = 1'b1,
   parameter logic [7:0] MFR_CODE  = 8'h1F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               id_req,
   output logic               xfer_req,
   output logic [7:0]         xfer_tx,
   output logic               xfer_last,
   input  logic               xfer_done,
   input  logic [7:0]         xfer_rx,
   output logic               geo_valid,
   output logic               geo_ok,
   output logic               geo_rev,
   output logic [PAGES_W-1:0] geo_pages,
   output logic [SIZE_W-1:0]  geo_size,
   output logic [SHIFT_W-1:0] geo_shift
);

   localparam int MAX_PAGES  = 8192;
   localparam int MAX_SIZE   = 1056;
   localparam int MAX_SHIFT  = 11;

   if (PAGES_W < $clog2(MAX_PAGES + 1)) begin : g_chk_pw
      $error("PAGES_W too narrow for the largest page count");
   end
   if (SIZE_W < $clog2(MAX_SIZE + 1)) begin : g_chk_sw
      $error("SIZE_W too narrow for the largest page size");
   end
   if (SHIFT_W < $clog2(MAX_SHIFT + 1)) begin : g_chk_hw
      $error("SHIFT_W too narrow for the largest shift");
   end

   logic [23:0] id_word;
   logic [7:0]  stat_byte;
   logic        legacy, commit, idle;
   fam_t        id_fam;
   logic        st_hit;
   logic [2:0]  st_pg;
   logic [1:0]  st_cls;

   flashgeo_seq #(.LEGACY_EN(LEGACY_EN), .MFR_CODE(MFR_CODE)) u_seq (
      .clk(clk), .rst_n(rst_n), .id_req(id_req),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx),
      .id_hit(id_fam.hit), .id_cap(id_fam.pow2cap),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
      .id_word(id_word), .stat_byte(stat_byte), .legacy(legacy),
      .commit(commit), .idle(idle)
   );

   flashgeo_idmap #(.MFR_CODE(MFR_CODE)) u_idmap (
      .id_word(id_word), .fam(id_fam)
   );

   if (LEGACY_EN) begin : g_legacy
      flashgeo_stdec u_stdec (
         .stat(stat_byte), .hit(st_hit), .pg_exp(st_pg), .sz_cls(st_cls)
      );
   end else begin : g_no_legacy
      assign st_hit = 1'b0;
      assign st_pg  = 3'd0;
      assign st_cls = 2'd0;
   end

   logic       found, binary, rev_nx;
   logic [2:0] sel_pg;
   logic [1:0] sel_cls;

   assign found   = legacy ? st_hit : id_fam.hit;
   assign sel_pg  = legacy ? st_pg  : id_fam.pg_exp;
   assign sel_cls = legacy ? st_cls : id_fam.sz_cls;
   assign binary  = !legacy && id_fam.pow2cap && stat_byte[0];
   assign rev_nx  = !legacy && id_fam.hit && id_fam.pow2cap;

   logic [PAGES_W-1:0] pages_nx;
   logic [SIZE_W-1:0]  size_nx;
   logic [SHIFT_W-1:0] shift_nx;

   flashgeo_shape #(.PAGES_W(PAGES_W), .SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W)) u_shape (
      .found(found), .pg_exp(sel_pg), .sz_cls(sel_cls), .binary(binary),
      .pages(pages_nx), .size(size_nx), .shift(shift_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         geo_ok    <= 1'b0;
         geo_rev   <= 1'b0;
         geo_pages <= '0;
         geo_size  <= '0;
         geo_shift <= '0;
      end else if (commit) begin
         geo_ok    <= found;
         geo_rev   <= rev_nx;
         geo_pages <= pages_nx;
         geo_size  <= size_nx;
         geo_shift <= shift_nx;
      end
   end

   assign geo_valid = idle;

endmodule

// File: rtl/flashgeo_chk.sv
module flashgeo_chk #(
   parameter int PAGES_W = 14,
   parameter int SIZE_W  = 11,
   parameter int SHIFT_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               id_req,
   input logic               xfer_req,
   input logic [7:0]         xfer_tx,
   input logic               xfer_last,
   input logic               xfer_done,
   input logic               geo_valid,
   input logic               geo_ok,
   input logic               geo_rev,
   input logic [PAGES_W-1:0] geo_pages,
   input logic [SIZE_W-1:0]  geo_size,
   input logic [SHIFT_W-1:0] geo_shift
);

   int sh_i, sz_i;
   assign sh_i = int'(geo_shift);
   assign sz_i = int'(geo_size);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_done |=> xfer_req && $stable(xfer_tx) && $stable(xfer_last)); // R10

   AST_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid |-> !xfer_req); // R9

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid && !id_req |=> geo_valid &&
         $stable({geo_ok, geo_rev, geo_pages, geo_size, geo_shift})); // R9

   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid && id_req |=> !geo_valid && xfer_req && xfer_tx == 8'h9F && !xfer_last); // R1

   AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid && !geo_ok |-> geo_pages == '0 && geo_size == '0 &&
         geo_shift == '0 && !geo_rev); // R11

   AST_SIZE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid && geo_ok |-> sh_i >= 8 && sh_i <= 11 &&
         (sz_i == (1 << sh_i) || sz_i == ((1 << (sh_i - 1)) + (1 << (sh_i - 6))))); // R3

   AST_REV_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid && geo_rev |-> geo_ok); // R8

endmodule

bind flashgeo flashgeo_chk #(.PAGES_W(PAGES_W), .SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_req(id_req),
   .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last), .xfer_done(xfer_done),
   .geo_valid(geo_valid), .geo_ok(geo_ok), .geo_rev(geo_rev),
   .geo_pages(geo_pages), .geo_size(geo_size), .geo_shift(geo_shift)
);

// File: tb/tb_flashgeo.sv
`timescale 1ns/1ps
module tb_flashgeo;

   localparam int PAGES_W = 14;
   localparam int SIZE_W  = 11;
   localparam int SHIFT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic id_req = 1'b0;
   logic xfer_req, xfer_last;
   logic [7:0] xfer_tx;
   logic xfer_done = 1'b0;
   logic [7:0] xfer_rx = 8'h00;
   logic geo_valid, geo_ok, geo_rev;
   logic [PAGES_W-1:0] geo_pages;
   logic [SIZE_W-1:0]  geo_size;
   logic [SHIFT_W-1:0] geo_shift;

   always #2 clk = ~clk;

   flashgeo #(.PAGES_W(PAGES_W), .SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W)) dut (
      .clk(clk), .rst_n(rst_n), .id_req(id_req),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx),
      .geo_valid(geo_valid), .geo_ok(geo_ok), .geo_rev(geo_rev),
      .geo_pages(geo_pages), .geo_size(geo_size), .geo_shift(geo_shift)
   );

   int total = 0;
   int bad = 0;

   // ---------------- flash model behind the byte port ----------------
   logic [23:0] mdl_id = 24'h000000;
   logic [7:0]  mdl_st = 8'h00;
   int lat = 0;
   int bidx = 0;
   logic [7:0] cur_op = 8'h00;
   logic [7:0] hold_tx = 8'h00;
   logic hold_last = 1'b0;
   int nframes = 0;
   int pvio = 0;
   int nbytes = 0;
   logic [7:0] fr_op [0:2047];
   int fr_len [0:2047];

   function automatic logic [7:0] answer(input logic [7:0] op, input int idx);
      if (op == 8'h9F && idx == 1) return mdl_id[23:16];
      if (op == 8'h9F && idx == 2) return mdl_id[15:8];
      if (op == 8'h9F && idx == 3) return mdl_id[7:0];
      if (op == 8'hD7 && idx == 1) return mdl_st;
      return 8'h5A;
   endfunction

   always @(posedge clk) begin
      xfer_done <= 1'b0;
      if (rst_n && xfer_req && !xfer_done) begin
         if (lat != 0 && (xfer_tx != hold_tx || xfer_last != hold_last))
            pvio <= pvio + 1;
         if (lat == 0) begin
            hold_tx   <= xfer_tx;
            hold_last <= xfer_last;
         end
         if (lat == 2) begin
            lat       <= 0;
            xfer_done <= 1'b1;
            nbytes    <= nbytes + 1;
            if (bidx == 0) cur_op <= xfer_tx;
            else if (xfer_tx != 8'h00) pvio <= pvio + 1;
            xfer_rx <= answer((bidx == 0) ? xfer_tx : cur_op, bidx);
            if (xfer_last) begin
               fr_op[nframes % 2048]  <= (bidx == 0) ? xfer_tx : cur_op;
               fr_len[nframes % 2048] <= bidx + 1;
               nframes <= nframes + 1;
               bidx <= 0;
            end else begin
               bidx <= bidx + 1;
            end
         end else begin
            lat <= lat + 1;
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check_eq(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic expect_geo(input logic [23:0] id, input logic [7:0] st,
                             output bit ok, output bit rev, output int pages,
                             output int size, output int shift, output bit sr,
                             output bit legacy);
      int cls;
      int pexp;
      bit bin;
      int b;
      int d1;
      ok = 0; rev = 0; pages = 0; size = 0; shift = 0; sr = 0;
      cls = 0; pexp = 0; bin = 0;
      d1 = int'(id[15:8]);
      legacy = (id[23:16] != 8'h1F);
      if (!legacy) begin
         if (d1 >= 8'h22 && d1 <= 8'h28 &&
             (id[7:0] == 8'h00 || (d1 == 8'h27 && id[7:0] == 8'h01))) begin
            ok = 1;
            rev = !(d1 == 8'h27 && id[7:0] == 8'h00);
            pexp = (d1 <= 8'h25) ? d1 - 8'h22 : ((d1 == 8'h26) ? 3 : 4);
            cls = (d1 <= 8'h25) ? 0 : ((d1 == 8'h28) ? 2 : 1);
            sr = rev;
            bin = rev && st[0];
         end
      end else begin
         int code;
         sr = 1;
         code = int'(st[5:2]);
         if (st != 8'h00 && st != 8'hFF) begin
            if (code == 3 || code == 5 || code == 7 || code == 9) begin
               ok = 1; pexp = (code - 3) / 2; cls = 0;
            end else if (code == 11) begin
               ok = 1; pexp = 3; cls = 1;
            end else if (code == 13) begin
               ok = 1; pexp = 4; cls = 1;
            end else if (code >= 14) begin
               ok = 1; pexp = 4; cls = 2;
            end
         end
      end
      if (ok) begin
         b = 8 + cls;
         pages = 512 << pexp;
         size  = bin ? (1 << b) : ((1 << b) + (1 << (b - 5)));
         shift = bin ? b : b + 1;
      end
   endtask

   task automatic wait_valid();
      while (!geo_valid) @(negedge clk);
   endtask

   task automatic judge(input logic [23:0] id, input logic [7:0] st, input int fbase, input int pbase);
      bit ok, rev, sr, legacy;
      int pages, size, shift;
      string tg;
      expect_geo(id, st, ok, rev, pages, size, shift, sr, legacy);
      tg = legacy ? "R7" : (id[15:0] == 16'h2700 ? "R2" : "R4");
      if (legacy && (st == 8'h00 || st == 8'hFF))
         check_eq("R6", "absent device ok", int'(geo_ok), 0);
      else if (!legacy && !ok)
         check_eq("R5", "unknown id ok", int'(geo_ok), 0);
      else
         check_eq(tg, "ok", int'(geo_ok), int'(ok));
      check_eq(tg, "pages", int'(geo_pages), pages);
      check_eq("R3", "size", int'(geo_size), size);
      check_eq("R3", "shift", int'(geo_shift), shift);
      check_eq("R8", "rev", int'(geo_rev), int'(rev));
      if (!ok)
         check_eq("R11", "zeroed fields", int'(geo_pages) + int'(geo_size) + int'(geo_shift), 0);
      check_eq("R1", "id frame opcode", int'(fr_op[fbase % 2048]), 8'h9F);
      check_eq("R1", "id frame length", fr_len[fbase % 2048], 4);
      check_eq(legacy ? "R6" : "R5", "frame count", nframes - fbase, sr ? 2 : 1);
      if (sr && nframes - fbase == 2) begin
         check_eq("R3", "status frame opcode", int'(fr_op[(fbase + 1) % 2048]), 8'hD7);
         check_eq("R3", "status frame length", fr_len[(fbase + 1) % 2048], 2);
      end
      check_eq("R10", "byte port protocol violations", pvio - pbase, 0);
   endtask

   task automatic run_one(input logic [23:0] id, input logic [7:0] st, input bit hold_chk);
      int fbase;
      int pbase;
      mdl_id = id;
      mdl_st = st;
      fbase = nframes;
      pbase = pvio;
      @(negedge clk);
      id_req = 1'b1;
      @(negedge clk);
      id_req = 1'b0;
      check_eq("R9", "valid cleared after request", int'(geo_valid), 0);
      wait_valid();
      judge(id, st, fbase, pbase);
      if (hold_chk) begin
         logic [31:0] snap;
         int nb;
         snap = {geo_ok, geo_rev, 2'b00, geo_shift, geo_size, 3'b000, geo_pages};
         nb = nbytes;
         mdl_st = ~st;
         mdl_id = ~id;
         repeat (25) @(negedge clk);
         check_eq("R9", "held result", int'({geo_ok, geo_rev, 2'b00, geo_shift, geo_size, 3'b000, geo_pages}), int'(snap));
         check_eq("R9", "valid held", int'(geo_valid), 1);
         check_eq("R9", "no bytes while held", nbytes - nb, 0);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      mdl_id = 24'h1F2600;
      mdl_st = 8'hA1;
      repeat (4) @(negedge clk);
      check_eq("R1", "valid during reset", int'(geo_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "valid right after reset", int'(geo_valid), 0);
      wait_valid();
      judge(24'h1F2600, 8'hA1, 0, 0);

      run_one(24'h1F2700, 8'h01, 1'b1);
      run_one(24'h1F2800, 8'h00, 1'b1);
      run_one(24'h000000, 8'hFF, 1'b1);

      for (int s = 0; s < 256; s++)
         run_one(24'h000000, 8'(s), 1'b0);
      for (int s = 0; s < 256; s += 37)
         run_one(24'hC2_2013, 8'(s), 1'b0);
      run_one(24'h1E2400, 8'h1C, 1'b0);
      run_one(24'hFF_FFFF, 8'h2C, 1'b0);

      for (int d = 8'h20; d <= 8'h29; d++) begin
         for (int lo = 0; lo < 4; lo++) begin
            for (int bit0 = 0; bit0 < 2; bit0++) begin
               logic [7:0] low;
               low = (lo == 3) ? 8'hFF : 8'(lo);
               run_one({8'h1F, 8'(d), low}, 8'(8'hA8 | bit0), 1'b0);
            end
         end
      end

      repeat (5) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule